// File: doc/BRIEF.md
# Serial link receive slot demultiplexer

This block takes the serial input stream of an AC'97-style link, coming from a codec, and splits each received frame into its slots. A rising edge on the sync input marks the start of a frame. The block shifts the bits in, decodes the tag slot that begins each frame, and then routes each valid PCM slot to one of two receive channels. The routing comes from a per-slot assignment register. Slots 1 and 2 carry codec status. They are kept in two status words of their own and never reach the PCM channels.

Each channel has a holding register and two flags, ready and overrun, plus an interrupt output. Software polls the channel status word, or waits for the interrupt, and then reads the held sample. If a sample is not read in time, the next one overwrites it and the channel records an overrun. Every input is sampled by one fast system clock. The bit clock is passed through a synchronizer, and its falling edges are detected inside the block.

The serial link has no way to stall the codec, so the block has no back-pressure. A sample that is not collected before the next one arrives is overwritten, and the overrun flag reports the loss. The register bus is a plain synchronous read/write port.

Top module: `acl_rx_demux`

## Requirements
- R1: After reset, both channel status words read 0 and both holding registers read 0. The assignment word (address 0) and the interrupt enable word (address 1) also read 0, and irq_a and irq_b are low.
- R2: A frame starts at the falling edge of bit_clk at which sync_in is first seen high after having been low. The bit sampled at that edge is the MSB of slot 0. Slot 0 is 16 bits wide and slots 1 to 12 are 20 bits wide, all MSB first. After slot 12, bits are ignored until the next sync rise. A sync rise in the middle of a frame restarts the frame at slot 0.
- R3: In slot 0, bit 15 marks the whole frame valid, and bit (15 - s) marks slot s valid, for s = 1 to 12. A slot is accepted only if both its own bit and the frame bit are set.
- R4: The assignment word at address 0 has a 2-bit field for each slot s from 3 to 12, at bits [2(s-3)+1 : 2(s-3)]. Field value 01 selects channel A and 10 selects channel B. Values 00 and 11 select no channel, and such a slot produces no received data.
- R5: An accepted slot 1 word is stored in the codec address word (address 6), and an accepted slot 2 word in the codec data word (address 7). Both are 20 bits. Neither slot ever reaches a channel.
- R6: An accepted word routed to a channel is written to that channel's holding register (A at address 3, B at address 5), and the channel's ready flag is set. If ready was already set, the channel's overrun flag is also set.
- R7: Reading a channel status word (A at address 2, B at address 4) returns {overrun, ready} in bits [1:0] and clears both flags. If a word arrives in the same cycle as the read, the arrival takes priority.
- R8: The interrupt enable word at address 1 uses bit 0 for A ready, bit 1 for A overrun, bit 2 for B ready and bit 3 for B overrun. Each irq output is high exactly while one of its channel's enabled flags is set.
- R9: When several slots are assigned to one channel, that channel receives their words in ascending slot order within each frame.
- R10: Read data appears on bus_rdata in the cycle after bus_re. A write with bus_we stores bus_wdata in the assignment word or the enable word, and reading that word back returns the stored value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than bit_clk |
| rst_n | input | 1 | Active-low reset |
| bit_clk | input | 1 | Link bit clock, sampled and edge-detected |
| sync_in | input | 1 | Frame sync from the link |
| sdata_in | input | 1 | Serial data from the codec |
| bus_addr | input | 3 | Register address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 20 | Write data |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 20 | Registered read data |
| irq_a | output | 1 | Channel A interrupt |
| irq_b | output | 1 | Channel B interrupt |

## Verification
The bench builds the block with its default parameters: a 16-bit tag slot, 20-bit data slots, 13 slots and a two-stage synchronizer. It drives the bit clock at one sixth of the system clock. At this rate the monitor can collect every routed word between two slots, so the order in which words are interleaved on a channel is observable. The same rate lets the bench send aborted frames, frames with invalid tags and the code 11 assignment through the full slot sequence within a few thousand cycles each.

// File: rtl/acl_rx_pkg.sv
package acl_rx_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [1:0] {
    RT_NONE  = 2'b00,
    RT_CH_A  = 2'b01,
    RT_CH_B  = 2'b10,
    RT_UNUSED = 2'b11
  } route_e;

  localparam logic [ADDR_W-1:0] ADR_ASSIGN = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_IEN    = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_STAT_A = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_HOLD_A = 3'd3;
  localparam logic [ADDR_W-1:0] ADR_STAT_B = 3'd4;
  localparam logic [ADDR_W-1:0] ADR_HOLD_B = 3'd5;
  localparam logic [ADDR_W-1:0] ADR_CADDR  = 3'd6;
  localparam logic [ADDR_W-1:0] ADR_CDATA  = 3'd7;
endpackage

// File: rtl/acl_rx_framer.sv
module acl_rx_framer #(
  parameter int TAG_W       = 16,
  parameter int SLOT_W      = 20,
  parameter int NUM_SLOTS   = 13,
  parameter int SYNC_STAGES = 2,
  localparam int SLOT_IW    = $clog2(NUM_SLOTS),
  localparam int BIT_IW     = $clog2(SLOT_W)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bit_clk,
  input  logic               sync_in,
  input  logic               sdata_in,
  output logic               word_vld,
  output logic [SLOT_IW-1:0] word_slot,
  output logic [SLOT_W-1:0]  word_data
);
  logic [2:0] stg [SYNC_STAGES];
  logic bclk_s, sync_s, sd_s;
  logic bclk_d, sync_d;
  logic fall, sync_rise;
  logic active;
  logic [SLOT_IW-1:0] slot_idx;
  logic [BIT_IW-1:0]  bit_idx;
  logic [SLOT_W-1:0]  shreg;
  logic [BIT_IW-1:0]  last_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC_STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= {bit_clk, sync_in, sdata_in};
      for (int i = 1; i < SYNC_STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign bclk_s    = stg[SYNC_STAGES-1][2];
  assign sync_s    = stg[SYNC_STAGES-1][1];
  assign sd_s      = stg[SYNC_STAGES-1][0];
  assign fall      = bclk_d & ~bclk_s;
  assign sync_rise = fall & sync_s & ~sync_d;
  assign last_bit  = (slot_idx == '0) ? BIT_IW'(TAG_W - 1) : BIT_IW'(SLOT_W - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk_d    <= 1'b0;
      sync_d    <= 1'b0;
      active    <= 1'b0;
      slot_idx  <= '0;
      bit_idx   <= '0;
      shreg     <= '0;
      word_vld  <= 1'b0;
      word_slot <= '0;
      word_data <= '0;
    end else begin
      bclk_d   <= bclk_s;
      word_vld <= 1'b0;
      if (fall) begin
        sync_d <= sync_s;
        if (sync_rise) begin
          active   <= 1'b1;
          slot_idx <= '0;
          bit_idx  <= BIT_IW'(1);
          shreg    <= SLOT_W'(sd_s);
        end else if (active) begin
          shreg <= {shreg[SLOT_W-2:0], sd_s};
          if (bit_idx == last_bit) begin
            word_vld  <= 1'b1;
            word_slot <= slot_idx;
            word_data <= {shreg[SLOT_W-2:0], sd_s};
            bit_idx   <= '0;
            if (slot_idx == SLOT_IW'(NUM_SLOTS - 1)) active <= 1'b0;
            else slot_idx <= slot_idx + 1'b1;
          end else begin
            bit_idx <= bit_idx + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/acl_rx_router.sv
module acl_rx_router
  import acl_rx_pkg::*;
#(
  parameter int TAG_W     = 16,
  parameter int SLOT_W    = 20,
  parameter int NUM_SLOTS = 13,
  localparam int SLOT_IW  = $clog2(NUM_SLOTS),
  localparam int MAP_W    = 2 * (NUM_SLOTS - 3)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               word_vld,
  input  logic [SLOT_IW-1:0] word_slot,
  input  logic [SLOT_W-1:0]  word_data,
  input  logic [MAP_W-1:0]   assign_map,
  output logic               push_a,
  output logic               push_b,
  output logic [SLOT_W-1:0]  push_data,
  output logic               frame_ok,
  output logic [SLOT_W-1:0]  codec_addr,
  output logic [SLOT_W-1:0]  codec_data
);
  logic [TAG_W-1:0] tag_q;
  logic   slot_ok;
  route_e rt;

  assign frame_ok = tag_q[TAG_W-1];

  always_comb begin
    slot_ok = 1'b0;
    for (int s = 1; s < NUM_SLOTS; s++)
      if (int'(word_slot) == s) slot_ok = tag_q[TAG_W-1] & tag_q[TAG_W-1-s];
  end

  always_comb begin
    rt = RT_NONE;
    for (int s = 3; s < NUM_SLOTS; s++)
      if (int'(word_slot) == s) rt = route_e'(assign_map[2*(s-3) +: 2]);
  end

  always_comb begin
    push_a    = 1'b0;
    push_b    = 1'b0;
    push_data = word_data;
    if (word_vld && slot_ok && (int'(word_slot) >= 3)) begin
      unique case (rt)
        RT_CH_A: push_a = 1'b1;
        RT_CH_B: push_b = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tag_q      <= '0;
      codec_addr <= '0;
      codec_data <= '0;
    end else if (word_vld) begin
      if (word_slot == '0) tag_q <= word_data[TAG_W-1:0];
      if (slot_ok && word_slot == SLOT_IW'(1)) codec_addr <= word_data;
      if (slot_ok && word_slot == SLOT_IW'(2)) codec_data <= word_data;
    end
  end
endmodule

// File: rtl/acl_rx_chan.sv
module acl_rx_chan #(
  parameter int W = 20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         clr,
  output logic [W-1:0] hold,
  output logic         rdy,
  output logic         ovr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold <= '0;
      rdy  <= 1'b0;
      ovr  <= 1'b0;
    end else if (push) begin
      hold <= push_data;
      rdy  <= 1'b1;
      ovr  <= rdy | (ovr & ~clr);
    end else if (clr) begin
      rdy <= 1'b0;
      ovr <= 1'b0;
    end
  end
endmodule

// File: rtl/acl_rx_demux.sv
module acl_rx_demux
  import acl_rx_pkg::*;
#(
  parameter int TAG_W       = 16,
  parameter int SLOT_W      = 20,
  parameter int NUM_SLOTS   = 13,
  parameter int SYNC_STAGES = 2,
  localparam int SLOT_IW    = $clog2(NUM_SLOTS),
  localparam int MAP_W      = 2 * (NUM_SLOTS - 3)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_clk,
  input  logic              sync_in,
  input  logic              sdata_in,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [SLOT_W-1:0] bus_wdata,
  input  logic              bus_re,
  output logic [SLOT_W-1:0] bus_rdata,
  output logic              irq_a,
  output logic              irq_b
);
  logic               word_vld;
  logic [SLOT_IW-1:0] word_slot;
  logic [SLOT_W-1:0]  word_data;
  logic [MAP_W-1:0]   assign_q;
  logic [3:0]         ien_q;
  logic               push_a, push_b, frame_ok;
  logic [SLOT_W-1:0]  pdata, codec_addr, codec_data;
  logic [1:0]         push_v, clr_v, rdy_v, ovr_v, irq_v;
  logic [SLOT_W-1:0]  hold_v [2];

  acl_rx_framer #(
    .TAG_W(TAG_W), .SLOT_W(SLOT_W), .NUM_SLOTS(NUM_SLOTS), .SYNC_STAGES(SYNC_STAGES)
  ) u_framer (
    .clk(clk), .rst_n(rst_n), .bit_clk(bit_clk), .sync_in(sync_in), .sdata_in(sdata_in),
    .word_vld(word_vld), .word_slot(word_slot), .word_data(word_data)
  );

  acl_rx_router #(
    .TAG_W(TAG_W), .SLOT_W(SLOT_W), .NUM_SLOTS(NUM_SLOTS)
  ) u_router (
    .clk(clk), .rst_n(rst_n), .word_vld(word_vld), .word_slot(word_slot),
    .word_data(word_data), .assign_map(assign_q), .push_a(push_a), .push_b(push_b),
    .push_data(pdata), .frame_ok(frame_ok), .codec_addr(codec_addr), .codec_data(codec_data)
  );

  assign push_v = {push_b, push_a};

  always_comb begin
    clr_v[0] = bus_re && (bus_addr == ADR_STAT_A);
    clr_v[1] = bus_re && (bus_addr == ADR_STAT_B);
  end

  for (genvar c = 0; c < 2; c++) begin : g_chan
    acl_rx_chan #(.W(SLOT_W)) u_chan (
      .clk(clk), .rst_n(rst_n), .push(push_v[c]), .push_data(pdata), .clr(clr_v[c]),
      .hold(hold_v[c]), .rdy(rdy_v[c]), .ovr(ovr_v[c])
    );
    assign irq_v[c] = (rdy_v[c] & ien_q[2*c]) | (ovr_v[c] & ien_q[2*c+1]);
  end

  assign irq_a = irq_v[0];
  assign irq_b = irq_v[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      assign_q <= '0;
      ien_q    <= '0;
    end else if (bus_we) begin
      if (bus_addr == ADR_ASSIGN) assign_q <= bus_wdata[MAP_W-1:0];
      if (bus_addr == ADR_IEN)    ien_q    <= bus_wdata[3:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata <= '0;
    end else if (bus_re) begin
      unique case (bus_addr)
        ADR_ASSIGN: bus_rdata <= SLOT_W'(assign_q);
        ADR_IEN:    bus_rdata <= SLOT_W'(ien_q);
        ADR_STAT_A: bus_rdata <= SLOT_W'({ovr_v[0], rdy_v[0]});
        ADR_HOLD_A: bus_rdata <= hold_v[0];
        ADR_STAT_B: bus_rdata <= SLOT_W'({ovr_v[1], rdy_v[1]});
        ADR_HOLD_B: bus_rdata <= hold_v[1];
        ADR_CADDR:  bus_rdata <= codec_addr;
        default:    bus_rdata <= codec_data;
      endcase
    end
  end
endmodule

// File: rtl/acl_rx_demux_chk.sv
module acl_rx_demux_chk #(
  parameter int SLOT_W  = 20,
  parameter int SLOT_IW = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic [1:0]         push_v,
  input logic [1:0]         clr_v,
  input logic [1:0]         rdy_v,
  input logic [1:0]         ovr_v,
  input logic [SLOT_W-1:0]  hold_a,
  input logic [SLOT_W-1:0]  pdata,
  input logic               word_vld,
  input logic [SLOT_IW-1:0] word_slot,
  input logic               frame_ok,
  input logic [3:0]         ien_q,
  input logic               irq_a,
  input logic               irq_b
);
  a_r6_ready_on_push: assert property (@(posedge clk) disable iff (!rst_n)
    push_v[0] |=> rdy_v[0] && (hold_a == $past(pdata)));

  a_r6_overrun_a: assert property (@(posedge clk) disable iff (!rst_n)
    push_v[0] && rdy_v[0] |=> ovr_v[0]);

  a_r6_overrun_b: assert property (@(posedge clk) disable iff (!rst_n)
    push_v[1] && rdy_v[1] |=> ovr_v[1]);

  a_r7_clear_a: assert property (@(posedge clk) disable iff (!rst_n)
    clr_v[0] && !push_v[0] |=> !rdy_v[0] && !ovr_v[0]);

  a_r7_clear_b: assert property (@(posedge clk) disable iff (!rst_n)
    clr_v[1] && !push_v[1] |=> !rdy_v[1] && !ovr_v[1]);

  a_r5_status_slots_unrouted: assert property (@(posedge clk) disable iff (!rst_n)
    word_vld && (int'(word_slot) < 3) |-> push_v == 2'b00);

  a_r3_frame_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (push_v != 2'b00) |-> frame_ok && word_vld);

  a_r4_single_channel: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(push_v));

  a_r8_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (ien_q == 4'b0000) |-> !irq_a && !irq_b);
endmodule

bind acl_rx_demux acl_rx_demux_chk #(.SLOT_W(SLOT_W), .SLOT_IW(SLOT_IW)) chk_i (
  .clk(clk), .rst_n(rst_n), .push_v(push_v), .clr_v(clr_v), .rdy_v(rdy_v), .ovr_v(ovr_v),
  .hold_a(hold_v[0]), .pdata(pdata), .word_vld(word_vld), .word_slot(word_slot),
  .frame_ok(frame_ok), .ien_q(ien_q), .irq_a(irq_a), .irq_b(irq_b)
);

// File: tb/acl_rx_demux_tb_top.sv
module acl_rx_demux_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_clk = 1'b0, sync_in = 1'b0, sdata_in = 1'b0;
  logic [2:0] bus_addr = '0;
  logic bus_we = 1'b0, bus_re = 1'b0;
  logic [19:0] bus_wdata = '0;
  logic [19:0] bus_rdata;
  logic irq_a, irq_b;

  always #2 clk = ~clk;

  acl_rx_demux dut_i (
    .clk(clk), .rst_n(rst_n), .bit_clk(bit_clk), .sync_in(sync_in), .sdata_in(sdata_in),
    .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_re(bus_re),
    .bus_rdata(bus_rdata), .irq_a(irq_a), .irq_b(irq_b)
  );

  int checks = 0, fails = 0;
  bit mon_en = 1'b0, done = 1'b0;
  logic [19:0] qa[$], qb[$];
  logic [19:0] cur_map = '0;
  logic [19:0] exp_caddr = '0, exp_cdata = '0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  task automatic bus_rd(input logic [2:0] a, output logic [19:0] d);
    bus_addr = a; bus_re = 1'b1;
    @(negedge clk);
    bus_re = 1'b0;
    d = bus_rdata;
  endtask

  task automatic bus_wr(input logic [2:0] a, input logic [19:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  function automatic logic [19:0] sval(input int f, input int s);
    return 20'((f * 40503 + s * 7919) ^ (s << 16));
  endfunction

  task automatic send_bit(input logic sy, input logic b);
    bit_clk = 1'b1; sync_in = sy; sdata_in = b;
    repeat (3) @(negedge clk);
    bit_clk = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  // Sends the first max_bits bits of a frame; model updated for completed slots only.
  task automatic send_frame(input int f, input logic [15:0] tag, input int max_bits);
    int sent = 0;
    for (int s = 1; s < 13; s++) begin
      if (max_bits >= 16 + 20 * s && tag[15] && tag[15-s]) begin
        if (s == 1) exp_caddr = sval(f, 1);
        else if (s == 2) exp_cdata = sval(f, 2);
        else if (cur_map[2*(s-3) +: 2] == 2'b01) qa.push_back(sval(f, s));
        else if (cur_map[2*(s-3) +: 2] == 2'b10) qb.push_back(sval(f, s));
      end
    end
    for (int i = 15; i >= 0 && sent < max_bits; i--) begin
      send_bit(1'b1, tag[i]); sent++;
    end
    for (int s = 1; s < 13; s++) begin
      logic [19:0] v = sval(f, s);
      for (int i = 19; i >= 0 && sent < max_bits; i--) begin
        send_bit(1'b0, v[i]); sent++;
      end
    end
    repeat (40) @(negedge clk);
  endtask

  task automatic mon_off();
    mon_en = 1'b0;
    repeat (20) @(negedge clk);
  endtask

  task automatic set_map(input logic [19:0] m);
    bus_wr(3'd0, m);
    cur_map = m;
  endtask

  // Monitor: pops the expected word for each channel event and compares.
  always begin
    logic [19:0] st, d, e;
    @(negedge clk);
    if (mon_en && irq_a) begin
      bus_rd(3'd2, st);
      bus_rd(3'd3, d);
      check(st == 20'h1, "R6 chA status on single word", st, 20'h1);
      if (qa.size() == 0) check(1'b0, "R4 unexpected word on chA", d, 0);
      else begin
        e = qa.pop_front();
        check(d == e, "R9 chA word order/value", d, e);
      end
    end
    if (mon_en && irq_b) begin
      bus_rd(3'd4, st);
      bus_rd(3'd5, d);
      check(st == 20'h1, "R6 chB status on single word", st, 20'h1);
      if (qb.size() == 0) check(1'b0, "R4 unexpected word on chB", d, 0);
      else begin
        e = qb.pop_front();
        check(d == e, "R9 chB word order/value", d, e);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R2 watchdog expired actual=0 expected=1");
      report();
      $finish;
    end
  end

  initial begin
    logic [19:0] d;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    check(irq_a == 0 && irq_b == 0, "R1 irq low", {irq_b, irq_a}, 0);
    bus_rd(3'd2, d); check(d == 0, "R1 chA status", d, 0);
    bus_rd(3'd4, d); check(d == 0, "R1 chB status", d, 0);
    bus_rd(3'd3, d); check(d == 0, "R1 chA hold", d, 0);
    bus_rd(3'd0, d); check(d == 0, "R1 assign word", d, 0);
    bus_rd(3'd1, d); check(d == 0, "R1 enable word", d, 0);

    // R10 readback, R4 basic routing: slot3->A, slot4->B
    set_map(20'h00009);
    bus_wr(3'd1, 20'h5);
    bus_rd(3'd0, d); check(d == 20'h00009, "R10 assign readback", d, 20'h00009);
    bus_rd(3'd1, d); check(d == 20'h5, "R10 enable readback", d, 20'h5);
    mon_en = 1'b1;
    send_frame(1, 16'hFFF8, 256);
    check(qa.size() == 0 && qb.size() == 0, "R4 basic routing drained", qa.size() + qb.size(), 0);

    // R9 interleave: 3,5,7 -> A; 6,8,12 -> B; 11 code 11 -> none
    mon_off();
    set_map(20'h000F9 ^ 20'h000F9 | 20'h00001 | 20'h00010 | 20'h00080 | 20'h00100 | 20'h00800 | 20'h30000 | 20'h80000);
    mon_en = 1'b1;
    send_frame(2, 16'hFFF8, 256);
    send_frame(3, 16'hFFF8, 256);
    check(qa.size() == 0 && qb.size() == 0, "R9 interleave drained", qa.size() + qb.size(), 0);

    // R3 slot 5 invalid bit, then whole frame invalid
    send_frame(4, 16'hFFF8 & ~16'h0400, 256);
    check(qa.size() == 0 && qb.size() == 0, "R3 slot gating drained", qa.size() + qb.size(), 0);
    send_frame(5, 16'h7FF8, 256);
    mon_off();
    bus_rd(3'd2, d); check(d == 0, "R3 invalid frame no chA word", d, 0);
    bus_rd(3'd4, d); check(d == 0, "R3 invalid frame no chB word", d, 0);

    // R5 codec status words kept from last valid frame
    bus_rd(3'd6, d); check(d == exp_caddr, "R5 codec address word", d, exp_caddr);
    bus_rd(3'd7, d); check(d == exp_cdata, "R5 codec data word", d, exp_cdata);

    // R6/R7/R8 overrun with slots 3 and 4 -> A
    set_map(20'h00005);
    bus_wr(3'd1, 20'h0);
    send_frame(6, 16'h9800, 256);
    check(irq_a == 0, "R8 irq masked", irq_a, 0);
    bus_wr(3'd1, 20'h2);
    @(negedge clk);
    check(irq_a == 1, "R8 irq on overrun enable", irq_a, 1);
    bus_rd(3'd3, d); check(d == sval(6, 4), "R6 overwrite keeps later slot", d, sval(6, 4));
    bus_rd(3'd2, d); check(d == 20'h3, "R6 overrun and ready", d, 20'h3);
    @(negedge clk);
    check(irq_a == 0, "R7 irq drops after status read", irq_a, 0);
    bus_rd(3'd2, d); check(d == 0, "R7 status cleared", d, 0);
    qa.delete();

    // R2 aborted frame, restart on new sync, trailing idle bits ignored
    set_map(20'h00002);
    bus_wr(3'd1, 20'h5);
    mon_en = 1'b1;
    send_frame(7, 16'hFFF8, 50);
    send_frame(8, 16'hFFF8, 256);
    for (int i = 0; i < 10; i++) send_bit(1'b0, 1'b1);
    repeat (40) @(negedge clk);
    check(qa.size() == 0 && qb.size() == 0, "R2 realigned frame drained", qa.size() + qb.size(), 0);
    mon_off();
    bus_rd(3'd6, d); check(d == sval(8, 1), "R2 codec address after restart", d, sval(8, 1));
    bus_rd(3'd4, d); check(d == 0, "R2 idle bits give no word", d, 0);

    done = 1'b1;
    report();
    $finish;
  end
endmodule